// File: doc/BRIEF.md
# E1 Resynchronization Criteria Monitor

This block sits beside an E1 receive framer and decides when the framer's current alignment should be abandoned. The framer reports, one strobe per received word, whether a frame alignment word, a CAS multiframe alignment word or a CRC-4 code word arrived intact or in error. The monitor keeps a run of consecutive errors for each of the two alignment word types. For CRC-4 it counts errored code words in back-to-back windows of 1000 words.

When a criterion is met, the matching sticky event bit is set in an 8-bit status register. A host reads that register and clears individual bits by writing ones. Each criterion has its own enable input. A synchronous clear input and the asynchronous reset both bring all counters and event bits back to zero.

Top module: `e1_resync_monitor`

## Requirements
- R1: Three frame alignment words in a row received in error set status bit 1, and the bit reads as 1 on the clock after the strobe of the third errored word.
- R2: Two CAS multiframe alignment words in a row received in error set status bit 0, and the bit reads as 1 on the clock after the strobe of the second errored word.
- R3: Status bit 2 is set on the clock after the CRC-4 strobe that brings the errored-word count of the current window to 915. The bit does not wait for the window to end.
- R4: The status register reads {5'b0, crc_event, fas_event, cas_event}. Bits 7 to 3 always read as zero.
- R5: After the asynchronous reset the status register reads 8'h00.
- R6: A correctly received word of one type restarts that type's consecutive-error run. Cycles without a strobe leave the run unchanged.
- R7: Once a run criterion fires, its run restarts from zero, so a further event needs the full number of consecutive errors again.
- R8: Event bits are sticky. Writing a 1 at a bit position clears only that bit, and writing 0 leaves the bit unchanged.
- R9: CRC-4 windows are 1000 consecutive code words, do not overlap and follow one another without a gap. The errored count restarts with each window, so errors that fall in two adjacent windows never combine.
- R10: When an event and a host clear of the same bit fall in one cycle, the bit ends up set.
- R11: While a criterion's enable is low, its counters are held at zero and its strobes are ignored. After the enable returns high, counting starts from zero and a new CRC-4 window begins.
- R12: A one-cycle synchronous clear pulse zeroes all counters and all event bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear of counters and event bits |
| fas_en_i | input | 1 | Enable for the frame alignment word criterion |
| cas_en_i | input | 1 | Enable for the CAS multiframe alignment word criterion |
| crc_en_i | input | 1 | Enable for the CRC-4 block error criterion |
| fas_stb_i | input | 1 | A frame alignment word was received |
| fas_err_i | input | 1 | That frame alignment word was in error |
| cas_stb_i | input | 1 | A CAS multiframe alignment word was received |
| cas_err_i | input | 1 | That CAS alignment word was in error |
| crc_stb_i | input | 1 | A CRC-4 code word was checked |
| crc_err_i | input | 1 | That CRC-4 code word was in error |
| reg_wr_i | input | 1 | Write strobe for the status register |
| reg_wdata_i | input | 8 | Write data. A 1 clears the matching event bit |
| reg_rdata_o | output | 8 | Status register contents |

## Verification
A new event and a host write that clears the same bit can land on the same clock edge. The bench provokes this by first setting the frame alignment event. It then sends two more errored words and issues the clearing write in the very cycle of the third errored strobe. The result is judged at the status port on the next cycle: the bit must still read 1. A plain clear with no event, and a write that targets other bit positions, are also checked, so both sides of the priority rule are seen.

// File: rtl/e1_resync_pkg.sv
package e1_resync_pkg;
  localparam int unsigned FAS_RUN_DEF = 3;
  localparam int unsigned CAS_RUN_DEF = 2;
  localparam int unsigned CRC_WIN_DEF = 1000;
  localparam int unsigned CRC_LIM_DEF = 915;
  localparam int unsigned STAT_W      = 8;
  localparam int unsigned N_EV        = 3;
  localparam int unsigned N_RUN       = 2;
  // status bit positions, decoded by host software
  localparam int unsigned EV_CAS = 0;
  localparam int unsigned EV_FAS = 1;
  localparam int unsigned EV_CRC = 2;
endpackage

// File: rtl/e1_run_counter.sv
module e1_run_counter #(
  parameter int unsigned THRESH = 3,
  parameter int unsigned CNT_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             err_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last  = (cnt_q == CNT_W'(THRESH - 1));
  assign hit_o = en_i && !srst_i && stb_i && err_i && last;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (srst_i || !en_i) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      if (!err_i || last) cnt_q <= '0;  // good word or criterion met: restart run
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/e1_crc_window.sv
module e1_crc_window #(
  parameter int unsigned WIN = 1000,
  parameter int unsigned LIM = 915
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         srst_i,
  input  logic                         en_i,
  input  logic                         stb_i,
  input  logic                         err_i,
  output logic                         hit_o,
  output logic [$clog2(LIM+1)-1:0]     err_cnt_o
);
  localparam int unsigned WW = $clog2(WIN);
  localparam int unsigned EW = $clog2(LIM + 1);

  logic [WW-1:0] word_q;
  logic [EW-1:0] err_q;
  logic          win_end;
  logic          at_lim;

  assign win_end   = (word_q == WW'(WIN - 1));
  assign at_lim    = (err_q == EW'(LIM));
  assign hit_o     = en_i && !srst_i && stb_i && err_i && (err_q == EW'(LIM - 1));
  assign err_cnt_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      err_q  <= '0;
    end else if (srst_i || !en_i) begin
      word_q <= '0;
      err_q  <= '0;
    end else if (stb_i) begin
      if (win_end) begin
        word_q <= '0;
        err_q  <= '0;
      end else begin
        word_q <= word_q + 1'b1;
        if (err_i && !at_lim) err_q <= err_q + 1'b1;  // saturate at limit
      end
    end
  end
endmodule

// File: rtl/e1_event_reg.sv
module e1_event_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (srst_i) q <= '0;
    else             q <= set_i | (q & ~clr_i);  // set wins over clear
  end

  assign q_o = q;
endmodule

// File: rtl/e1_resync_monitor.sv
module e1_resync_monitor
  import e1_resync_pkg::*;
#(
  parameter int unsigned FAS_RUN = FAS_RUN_DEF,
  parameter int unsigned CAS_RUN = CAS_RUN_DEF,
  parameter int unsigned CRC_WIN = CRC_WIN_DEF,
  parameter int unsigned CRC_LIM = CRC_LIM_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              fas_en_i,
  input  logic              cas_en_i,
  input  logic              crc_en_i,
  input  logic              fas_stb_i,
  input  logic              fas_err_i,
  input  logic              cas_stb_i,
  input  logic              cas_err_i,
  input  logic              crc_stb_i,
  input  logic              crc_err_i,
  input  logic              reg_wr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o
);
  localparam int unsigned RUN_MAX = (FAS_RUN > CAS_RUN) ? FAS_RUN : CAS_RUN;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);
  localparam int unsigned CRC_EW  = $clog2(CRC_LIM + 1);

  logic [N_RUN-1:0]            run_stb, run_err, run_en, run_hit;
  logic [N_RUN-1:0][RUN_W-1:0] run_cnt;
  logic                        crc_hit;
  logic [CRC_EW-1:0]           crc_err_cnt;
  logic [N_EV-1:0]             ev_hit, ev_clr, ev_q;
  logic                        unused_wdata;

  assign run_stb[EV_CAS] = cas_stb_i;
  assign run_err[EV_CAS] = cas_err_i;
  assign run_en[EV_CAS]  = cas_en_i;
  assign run_stb[EV_FAS] = fas_stb_i;
  assign run_err[EV_FAS] = fas_err_i;
  assign run_en[EV_FAS]  = fas_en_i;

  for (genvar g = 0; g < N_RUN; g++) begin : g_run
    localparam int unsigned TH = (g == EV_FAS) ? FAS_RUN : CAS_RUN;
    e1_run_counter #(
      .THRESH(TH),
      .CNT_W (RUN_W)
    ) u_run (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .srst_i(srst_i),
      .en_i  (run_en[g]),
      .stb_i (run_stb[g]),
      .err_i (run_err[g]),
      .hit_o (run_hit[g]),
      .cnt_o (run_cnt[g])
    );
  end

  e1_crc_window #(
    .WIN(CRC_WIN),
    .LIM(CRC_LIM)
  ) u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst_i),
    .en_i     (crc_en_i),
    .stb_i    (crc_stb_i),
    .err_i    (crc_err_i),
    .hit_o    (crc_hit),
    .err_cnt_o(crc_err_cnt)
  );

  assign ev_hit[EV_CAS] = run_hit[EV_CAS];
  assign ev_hit[EV_FAS] = run_hit[EV_FAS];
  assign ev_hit[EV_CRC] = crc_hit;
  assign ev_clr         = {N_EV{reg_wr_i}} & reg_wdata_i[N_EV-1:0];
  assign unused_wdata   = ^reg_wdata_i[STAT_W-1:N_EV];

  e1_event_reg #(
    .N(N_EV)
  ) u_ev (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .srst_i(srst_i),
    .set_i (ev_hit),
    .clr_i (ev_clr),
    .q_o   (ev_q)
  );

  assign reg_rdata_o = {{(STAT_W - N_EV){1'b0}}, ev_q};
endmodule

// File: rtl/e1_resync_monitor_chk.sv
module e1_resync_monitor_chk #(
  parameter int unsigned FAS_RUN = 3,
  parameter int unsigned CAS_RUN = 2,
  parameter int unsigned CRC_LIM = 915,
  parameter int unsigned RUN_W   = 2,
  parameter int unsigned CRC_EW  = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  srst_i,
  input logic                  fas_en_i,
  input logic                  cas_en_i,
  input logic                  crc_en_i,
  input logic                  fas_stb_i,
  input logic                  fas_err_i,
  input logic                  cas_stb_i,
  input logic                  cas_err_i,
  input logic                  crc_stb_i,
  input logic                  crc_err_i,
  input logic                  reg_wr_i,
  input logic [7:0]            reg_wdata_i,
  input logic [7:0]            reg_rdata_o,
  input logic                  fas_hit,
  input logic [1:0][RUN_W-1:0] run_cnt,
  input logic [CRC_EW-1:0]     crc_err_cnt
);
  assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:3] == 5'd0);

  assert_cas_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[0]) |-> $past(cas_stb_i && cas_err_i && cas_en_i));

  assert_fas_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[1]) |-> $past(fas_stb_i && fas_err_i && fas_en_i));

  assert_crc_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[2]) |-> $past(crc_stb_i && crc_err_i && crc_en_i));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && !srst_i && !(reg_wr_i && reg_wdata_i[0])) |=> reg_rdata_o[0]);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[1] && !fas_stb_i) |=> !reg_rdata_o[1]);

  assert_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fas_hit && reg_wr_i && reg_wdata_i[1]) |=> reg_rdata_o[1]);

  assert_run_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_cnt[1] < RUN_W'(FAS_RUN)) && (run_cnt[0] < RUN_W'(CAS_RUN)));

  assert_crc_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_cnt <= CRC_EW'(CRC_LIM));

  assert_disabled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fas_en_i && !cas_en_i && !crc_en_i) |=>
      (run_cnt[1] == '0 && run_cnt[0] == '0 && crc_err_cnt == '0));

  assert_srst_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (reg_rdata_o == 8'h00));
endmodule

bind e1_resync_monitor e1_resync_monitor_chk #(
  .FAS_RUN(FAS_RUN),
  .CAS_RUN(CAS_RUN),
  .CRC_LIM(CRC_LIM),
  .RUN_W  (RUN_W),
  .CRC_EW (CRC_EW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .srst_i     (srst_i),
  .fas_en_i   (fas_en_i),
  .cas_en_i   (cas_en_i),
  .crc_en_i   (crc_en_i),
  .fas_stb_i  (fas_stb_i),
  .fas_err_i  (fas_err_i),
  .cas_stb_i  (cas_stb_i),
  .cas_err_i  (cas_err_i),
  .crc_stb_i  (crc_stb_i),
  .crc_err_i  (crc_err_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .fas_hit    (run_hit[1]),
  .run_cnt    (run_cnt),
  .crc_err_cnt(crc_err_cnt)
);

// File: tb/e1_resync_monitor_tb_top.sv
module e1_resync_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0;
  logic       fas_en = 1'b1, cas_en = 1'b1, crc_en = 1'b1;
  logic       fas_stb = 1'b0, fas_err = 1'b0;
  logic       cas_stb = 1'b0, cas_err = 1'b0;
  logic       crc_stb = 1'b0, crc_err = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  e1_resync_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst),
    .fas_en_i(fas_en), .cas_en_i(cas_en), .crc_en_i(crc_en),
    .fas_stb_i(fas_stb), .fas_err_i(fas_err),
    .cas_stb_i(cas_stb), .cas_err_i(cas_err),
    .crc_stb_i(crc_stb), .crc_err_i(crc_err),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: status=%h expected=%h", req, rdata, exp);
    end
  endtask

  task automatic fas_word(input logic e);
    @(negedge clk); fas_stb = 1'b1; fas_err = e;
    @(negedge clk); fas_stb = 1'b0; fas_err = 1'b0;
  endtask

  task automatic cas_word(input logic e);
    @(negedge clk); cas_stb = 1'b1; cas_err = e;
    @(negedge clk); cas_stb = 1'b0; cas_err = 1'b0;
  endtask

  task automatic crc_words(input int n, input logic e);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); crc_stb = 1'b1; crc_err = e;
    end
    @(negedge clk); crc_stb = 1'b0; crc_err = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic t_reset;
    chk("R5 reset value", 8'h00);
    reg_write(8'hFF);
    chk("R4 upper bits read zero", 8'h00);
  endtask

  task automatic t_fas;
    fas_word(1); fas_word(1); fas_word(0);
    fas_word(1); fas_word(1);
    repeat (3) @(negedge clk);
    chk("R6 good word restarts FAS run", 8'h00);
    fas_word(1);
    chk("R1 third consecutive FAS error", 8'h02);
    reg_write(8'h05);
    chk("R8 write to other bits keeps FAS bit", 8'h02);
    reg_write(8'h02);
    chk("R8 write one clears FAS bit", 8'h00);
    fas_word(1); fas_word(1);
    chk("R7 run restarted after event", 8'h00);
    fas_word(1);
    chk("R7 event again after full run", 8'h02);
    reg_write(8'h02);
  endtask

  task automatic t_cas;
    cas_word(1); cas_word(0); cas_word(1);
    chk("R6 good word restarts CAS run", 8'h00);
    cas_word(1);
    chk("R2 second consecutive CAS error", 8'h01);
    reg_write(8'h01);
    chk("R8 write one clears CAS bit", 8'h00);
  endtask

  task automatic t_crc;
    // window 1: 86 good then 914 errored; window 2 opens with 914 errored
    crc_words(86, 0);
    crc_words(914, 1);
    chk("R3 914 errors in window no event", 8'h00);
    crc_words(914, 1);
    crc_words(86, 0);
    chk("R9 errors across windows do not combine", 8'h00);
    crc_words(914, 1);
    chk("R3 914 of window 3 no event", 8'h00);
    crc_words(1, 1);
    chk("R3 event at 915th error before window end", 8'h04);
    crc_words(85, 0);
    reg_write(8'h04);
    chk("R8 write one clears CRC bit", 8'h00);
  endtask

  task automatic t_priority;
    fas_word(1); fas_word(1); fas_word(1);
    chk("R10 precondition FAS bit set", 8'h02);
    fas_word(1); fas_word(1);
    @(negedge clk); fas_stb = 1'b1; fas_err = 1'b1; wr = 1'b1; wdata = 8'h02;
    @(negedge clk); fas_stb = 1'b0; fas_err = 1'b0; wr = 1'b0; wdata = 8'h00;
    chk("R10 event wins over same-cycle clear", 8'h02);
    reg_write(8'h02);
  endtask

  task automatic t_enable;
    fas_word(1); fas_word(1);
    @(negedge clk); fas_en = 1'b0;
    @(negedge clk); fas_en = 1'b1;
    fas_word(1);
    chk("R11 FAS disable zeroes run", 8'h00);
    @(negedge clk); cas_en = 1'b0;
    cas_word(1); cas_word(1); cas_word(1);
    chk("R11 CAS strobes ignored while disabled", 8'h00);
    @(negedge clk); cas_en = 1'b1;
    crc_words(914, 1);
    @(negedge clk); crc_en = 1'b0;
    @(negedge clk); crc_en = 1'b1;
    crc_words(1, 1);
    chk("R11 CRC disable zeroes errored count", 8'h00);
    crc_words(999, 0);
  endtask

  task automatic t_srst;
    cas_word(1);
    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    cas_word(1);
    chk("R12 sync clear zeroes CAS run", 8'h00);
    cas_word(1);
    fas_word(1); fas_word(1); fas_word(1);
    chk("R12 precondition two bits set", 8'h03);
    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    chk("R12 sync clear zeroes event bits", 8'h00);
  endtask

  initial begin
    #4ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fas();
    t_cas();
    t_crc();
    t_priority();
    t_enable();
    t_srst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule